// File: doc/BRIEF.md
# Virtual Link Frame Filter

This block sits on the receive byte stream of a deterministic avionics Ethernet port and decides, frame by frame, whether a frame continues to the redundancy stage or is thrown away. It parses the Ethernet, IPv4 and UDP headers of each frame and takes a 16-bit virtual link number from the destination MAC address. That number indexes a configuration table with one entry per link. A link that has no enabled entry is dropped, so the filter denies everything by default.

Each table entry can also narrow the match to a given IPv4 source address, IPv4 destination address, UDP source port and UDP destination port. Every one of these compares has its own enable, so a cleared enable means "don't care". The entry also carries two per-link option bits, integrity checking and redundancy management. With an accept verdict, the filter passes these bits downstream together with the link number.

A host processor writes the table through a simple write port while the datapath reads it. The table is a behavioural dual-port array. Its depth is set by a parameter, and the full 16-bit link space uses a 16-bit index. The table is read while the header is still being parsed, so the read latency adds nothing to the verdict time.

Top module: `vl_frame_filter`

## Requirements
- R1: After reset the enable bit of every table entry is cleared, so every frame gets a drop verdict until its link is written with the enable bit set.
- R2: The link number is formed from frame bytes 4 (high) and 5 (low), the low 16 bits of the destination MAC. It indexes the table directly. A link number at or above the table depth (2^IDX_W) is dropped.
- R3: Frame bytes 0 to 3 (the upper 32 bits of the destination MAC, byte 0 most significant) must equal MAC_PREFIX, or the frame is dropped.
- R4: A write on the cfg port stores `cfg_entry_i` at `cfg_addr_i` and affects the frames that follow. The entry bit layout is: 102 link enable, 101 integrity enable, 100 redundancy enable, 99 source IP compare enable, 98 destination IP compare enable, 97 source port compare enable, 96 destination port compare enable, [95:64] source IP, [63:32] destination IP, [31:16] source port, [15:0] destination port. Clearing the enable bit again makes the link drop.
- R5: With the source IP compare enable set, frame bytes 26 to 29 (byte 26 most significant) must equal the entry's source IP. With it cleared, those bytes have no effect.
- R6: With the destination IP compare enable set, frame bytes 30 to 33 must equal the entry's destination IP. With it cleared, those bytes have no effect.
- R7: With the source port compare enable set, frame bytes 34 and 35 must equal the entry's source port. With it cleared, those bytes have no effect.
- R8: With the destination port compare enable set, frame bytes 36 and 37 must equal the entry's destination port. With it cleared, those bytes have no effect.
- R9: A frame of 42 bytes or more gets exactly one verdict, one cycle after byte 41 (the last UDP header byte) is accepted, whatever idle cycles lie between bytes. Bytes after byte 41 produce no further verdict.
- R10: A frame whose last byte comes before byte 41 gets a drop verdict one cycle after its last byte.
- R11: An accept verdict carries the link number and the entry's integrity and redundancy enables. A drop verdict drives both option outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_last_i | input | 1 | Marks the last byte of a frame |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_addr_i | input | IDX_W | Table write index |
| cfg_entry_i | input | 103 | Table entry written (layout in R4) |
| vrd_valid_o | output | 1 | Verdict strobe |
| vrd_accept_o | output | 1 | 1 = accept, 0 = drop |
| vrd_vl_o | output | 16 | Link number of the judged frame |
| vrd_ic_en_o | output | 1 | Integrity checking enable of the accepted link |
| vrd_rm_en_o | output | 1 | Redundancy management enable of the accepted link |

## Verification
Some checks run on every cycle. Assertions check that a runt frame always gets a drop verdict on the cycle after its last byte, and that every verdict follows an accepted byte. They also check that an accept never goes out with a bad MAC prefix or an out-of-range link, that the option bits are zero on a drop, that a table write lands in the enable array, and that the header byte counter saturates. Other behaviour needs the bench's scenarios: the exact verdict cycle for long frames with and without idle gaps, deny-by-default before configuration, and each of the four optional compares taken with matching and mismatching headers. The bench also checks the don't-care case of each compare, a write that re-disables a link, aliasing of out-of-range link numbers, and the absence of a second verdict for bytes past the header.

// File: rtl/vlf_pkg.sv
package vlf_pkg;
  localparam int unsigned HDR_BYTES = 42;  // header ends after UDP header
  localparam int unsigned OFF_VL    = 4;
  localparam int unsigned OFF_SIP   = 26;
  localparam int unsigned OFF_DIP   = 30;
  localparam int unsigned OFF_SP    = 34;
  localparam int unsigned OFF_DP    = 36;

  typedef struct packed {
    logic        en;
    logic        ic_en;
    logic        rm_en;
    logic        sip_en;
    logic        dip_en;
    logic        sp_en;
    logic        dp_en;
    logic [31:0] sip;
    logic [31:0] dip;
    logic [15:0] sp;
    logic [15:0] dp;
  } vl_entry_t;

  localparam int unsigned ENTRY_W = $bits(vl_entry_t);
endpackage

// File: rtl/vlf_hdr_parser.sv
module vlf_hdr_parser
  import vlf_pkg::*;
#(
  parameter logic [31:0] MAC_PREFIX = 32'h0300_0000,
  localparam int unsigned CNT_W = $clog2(HDR_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [7:0]       data_i,
  input  logic             last_i,
  output logic [15:0]      vl_id_o,
  output logic [31:0]      sip_o,
  output logic [31:0]      dip_o,
  output logic [15:0]      sp_o,
  output logic [15:0]      dp_o,
  output logic             prefix_ok_o,
  output logic             hdr_end_o,
  output logic             runt_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(HDR_BYTES - 1);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(HDR_BYTES);

  logic [CNT_W-1:0] cnt_q;
  logic             pref_bad_q;
  logic [7:0]       pref_byte;

  function automatic logic in_fld(input logic [CNT_W-1:0] c, input int unsigned off,
                                  input int unsigned n);
    return (32'(c) >= off) && (32'(c) < off + n);
  endfunction

  always_comb begin
    case (cnt_q[1:0])
      2'd0:    pref_byte = MAC_PREFIX[31:24];
      2'd1:    pref_byte = MAC_PREFIX[23:16];
      2'd2:    pref_byte = MAC_PREFIX[15:8];
      default: pref_byte = MAC_PREFIX[7:0];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      pref_bad_q <= 1'b0;
      vl_id_o    <= '0;
      sip_o      <= '0;
      dip_o      <= '0;
      sp_o       <= '0;
      dp_o       <= '0;
    end else if (valid_i) begin
      if (last_i)              cnt_q <= '0;
      else if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == '0)         pref_bad_q <= (data_i != pref_byte);
      else if (cnt_q < CNT_W'(4)) pref_bad_q <= pref_bad_q | (data_i != pref_byte);
      if (in_fld(cnt_q, OFF_VL, 2))  vl_id_o <= {vl_id_o[7:0], data_i};
      if (in_fld(cnt_q, OFF_SIP, 4)) sip_o   <= {sip_o[23:0], data_i};
      if (in_fld(cnt_q, OFF_DIP, 4)) dip_o   <= {dip_o[23:0], data_i};
      if (in_fld(cnt_q, OFF_SP, 2))  sp_o    <= {sp_o[7:0], data_i};
      if (in_fld(cnt_q, OFF_DP, 2))  dp_o    <= {dp_o[7:0], data_i};
    end
  end

  assign prefix_ok_o = !pref_bad_q;
  assign hdr_end_o   = valid_i && (cnt_q == CNT_END);
  assign runt_o      = valid_i && last_i && (cnt_q < CNT_END);
  assign cnt_o       = cnt_q;

  p_cnt_sat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_SAT);
endmodule

// File: rtl/vlf_vl_table.sv
module vlf_vl_table
  import vlf_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  vl_entry_t        wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output vl_entry_t        rdata_o
);
  vl_entry_t mem_q [DEPTH];
  logic      en_q  [DEPTH];
  vl_entry_t rd_q;
  logic      en_rd_q;

  // enables are flops so the table is deny-all out of reset
  for (genvar i = 0; i < DEPTH; i++) begin : g_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               en_q[i] <= 1'b0;
      else if (we_i && waddr_i == IDX_W'(i))     en_q[i] <= wdata_i.en;
    end
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rd_q <= mem_q[raddr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_rd_q <= 1'b0;
    else         en_rd_q <= en_q[raddr_i];
  end

  always_comb begin
    rdata_o    = rd_q;
    rdata_o.en = en_rd_q;
  end

  p_write_lands_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (en_q[$past(waddr_i)] == $past(wdata_i.en)));
endmodule

// File: rtl/vlf_match.sv
module vlf_match
  import vlf_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        hdr_end_i,
  input  logic        runt_i,
  input  logic        prefix_ok_i,
  input  logic [15:0] vl_id_i,
  input  logic [31:0] sip_i,
  input  logic [31:0] dip_i,
  input  logic [15:0] sp_i,
  input  logic [15:0] dp_i,
  input  vl_entry_t   entry_i,
  output logic        vrd_valid_o,
  output logic        vrd_accept_o,
  output logic [15:0] vrd_vl_o,
  output logic        vrd_ic_en_o,
  output logic        vrd_rm_en_o
);
  logic in_range, fld_ok, hit;

  assign in_range = (vl_id_i >> IDX_W) == 16'd0;
  assign fld_ok   = (!entry_i.sip_en || sip_i == entry_i.sip) &&
                    (!entry_i.dip_en || dip_i == entry_i.dip) &&
                    (!entry_i.sp_en  || sp_i  == entry_i.sp)  &&
                    (!entry_i.dp_en  || dp_i  == entry_i.dp);
  assign hit      = hdr_end_i && prefix_ok_i && in_range && entry_i.en && fld_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vrd_valid_o  <= 1'b0;
      vrd_accept_o <= 1'b0;
      vrd_vl_o     <= '0;
      vrd_ic_en_o  <= 1'b0;
      vrd_rm_en_o  <= 1'b0;
    end else begin
      vrd_valid_o  <= hdr_end_i || runt_i;
      vrd_accept_o <= hit;
      if (hdr_end_i || runt_i) vrd_vl_o <= vl_id_i;
      vrd_ic_en_o  <= hit && entry_i.ic_en;
      vrd_rm_en_o  <= hit && entry_i.rm_en;
    end
  end

  p_drop_opts_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vrd_valid_o && !vrd_accept_o) |-> (!vrd_ic_en_o && !vrd_rm_en_o));
  p_accept_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vrd_accept_o |-> (vrd_valid_o && (vrd_vl_o >> IDX_W) == 16'd0));
endmodule

// File: rtl/vl_frame_filter.sv
module vl_frame_filter
  import vlf_pkg::*;
#(
  parameter int unsigned IDX_W      = 8,
  parameter logic [31:0] MAC_PREFIX = 32'h0300_0000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rx_valid_i,
  input  logic [7:0]         rx_data_i,
  input  logic               rx_last_i,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_addr_i,
  input  logic [ENTRY_W-1:0] cfg_entry_i,
  output logic               vrd_valid_o,
  output logic               vrd_accept_o,
  output logic [15:0]        vrd_vl_o,
  output logic               vrd_ic_en_o,
  output logic               vrd_rm_en_o
);
  localparam int unsigned CNT_W = $clog2(HDR_BYTES + 1);

  logic [15:0]      vl_id;
  logic [31:0]      sip, dip;
  logic [15:0]      sp, dp;
  logic             prefix_ok, hdr_end, runt;
  logic [CNT_W-1:0] cnt;
  vl_entry_t        entry;

  vlf_hdr_parser #(.MAC_PREFIX(MAC_PREFIX)) u_parser (
    .clk_i, .rst_ni,
    .valid_i(rx_valid_i), .data_i(rx_data_i), .last_i(rx_last_i),
    .vl_id_o(vl_id), .sip_o(sip), .dip_o(dip), .sp_o(sp), .dp_o(dp),
    .prefix_ok_o(prefix_ok), .hdr_end_o(hdr_end), .runt_o(runt), .cnt_o(cnt)
  );

  // read address settles at byte 6; entry is stable long before byte 41
  vlf_vl_table #(.IDX_W(IDX_W)) u_table (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .waddr_i(cfg_addr_i), .wdata_i(vl_entry_t'(cfg_entry_i)),
    .raddr_i(vl_id[IDX_W-1:0]), .rdata_o(entry)
  );

  vlf_match #(.IDX_W(IDX_W)) u_match (
    .clk_i, .rst_ni,
    .hdr_end_i(hdr_end), .runt_i(runt), .prefix_ok_i(prefix_ok),
    .vl_id_i(vl_id), .sip_i(sip), .dip_i(dip), .sp_i(sp), .dp_i(dp),
    .entry_i(entry),
    .vrd_valid_o, .vrd_accept_o, .vrd_vl_o, .vrd_ic_en_o, .vrd_rm_en_o
  );

  p_runt_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_last_i && cnt < CNT_W'(HDR_BYTES - 1)) |=>
      (vrd_valid_o && !vrd_accept_o));
  p_verdict_after_byte_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vrd_valid_o |-> $past(rx_valid_i));
  p_accept_prefix_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vrd_valid_o && vrd_accept_o) |-> $past(prefix_ok));
endmodule

// File: tb/tb_vl_frame_filter.sv
`timescale 1ns/1ps
module tb_vl_frame_filter;
  localparam int unsigned IDX_W  = 8;
  localparam int unsigned DEPTH  = 1 << IDX_W;
  localparam logic [31:0] PREFIX = 32'h0300_0000;

  typedef struct {
    int   cyc;
    logic acc;
    logic [15:0] vl;
    logic ic;
    logic rm;
    string tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0] rx_data = '0;
  logic cfg_we = 1'b0;
  logic [IDX_W-1:0] cfg_addr = '0;
  logic [102:0] cfg_entry = '0;
  logic vrd_valid, vrd_accept, vrd_ic, vrd_rm;
  logic [15:0] vrd_vl;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  exp_t q[$];
  logic         m_en  [DEPTH];
  logic [102:0] m_tab [DEPTH];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vl_frame_filter #(.IDX_W(IDX_W), .MAC_PREFIX(PREFIX)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_last_i(rx_last),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_entry_i(cfg_entry),
    .vrd_valid_o(vrd_valid), .vrd_accept_o(vrd_accept), .vrd_vl_o(vrd_vl),
    .vrd_ic_en_o(vrd_ic), .vrd_rm_en_o(vrd_rm)
  );

  function automatic logic [102:0] mk_entry(logic en, logic ic, logic rm, logic [3:0] cmp,
      logic [31:0] sip, logic [31:0] dip, logic [15:0] sp, logic [15:0] dp);
    return {en, ic, rm, cmp, sip, dip, sp, dp};
  endfunction

  task automatic cfg_write(input int idx, input logic [102:0] e);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = IDX_W'(idx); cfg_entry = e;
    @(negedge clk);
    cfg_we = 1'b0;
    m_en[idx]  = e[102];
    m_tab[idx] = e;
  endtask

  function automatic logic model_acc(logic [31:0] hi, logic [15:0] vl, logic [31:0] sip,
      logic [31:0] dip, logic [15:0] sp, logic [15:0] dp, int len);
    logic [102:0] e;
    if (len < 42 || hi != PREFIX || vl >= 16'(DEPTH)) return 1'b0;
    if (!m_en[vl]) return 1'b0;
    e = m_tab[vl];
    if (e[99] && sip != e[95:64]) return 1'b0;
    if (e[98] && dip != e[63:32]) return 1'b0;
    if (e[97] && sp  != e[31:16]) return 1'b0;
    if (e[96] && dp  != e[15:0])  return 1'b0;
    return 1'b1;
  endfunction

  task automatic send(input string tag, input logic [31:0] hi, input logic [15:0] vl,
      input logic [31:0] sip, input logic [31:0] dip, input logic [15:0] sp,
      input logic [15:0] dp, input int len, input bit gap);
    logic [7:0] b;
    exp_t e;
    int hend;
    e.acc = model_acc(hi, vl, sip, dip, sp, dp, len);
    e.vl  = vl;
    e.ic  = e.acc && m_tab[vl[IDX_W-1:0]][101];
    e.rm  = e.acc && m_tab[vl[IDX_W-1:0]][100];
    e.tag = tag;
    hend  = (len < 42) ? len - 1 : 41;
    for (int k = 0; k < len; k++) begin
      if (k < 4)        b = hi[8*(3-k) +: 8];
      else if (k < 6)   b = vl[8*(5-k) +: 8];
      else if (k == 12) b = 8'h08;
      else if (k == 13) b = 8'h00;
      else if (k >= 26 && k < 30) b = sip[8*(29-k) +: 8];
      else if (k >= 30 && k < 34) b = dip[8*(33-k) +: 8];
      else if (k >= 34 && k < 36) b = sp[8*(35-k) +: 8];
      else if (k >= 36 && k < 38) b = dp[8*(37-k) +: 8];
      else              b = 8'(k) ^ 8'hA5;
      @(negedge clk);
      rx_valid = 1'b1; rx_data = b; rx_last = (k == len - 1);
      if (k == hend) begin
        e.cyc = cyc + 1;
        q.push_back(e);
      end
      if (gap) begin
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
      end
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && vrd_valid) begin
      exp_t e;
      total++;
      if (q.size() == 0) begin
        bad++;
        $display("FAIL %s: unexpected verdict actual=acc%0d expected=none", "R9", vrd_accept);
      end else begin
        e = q.pop_front();
        if (cyc != e.cyc || vrd_accept != e.acc || vrd_ic != e.ic || vrd_rm != e.rm ||
            (e.acc && vrd_vl != e.vl)) begin
          bad++;
          $display("FAIL %s: actual cyc=%0d acc=%0d vl=%0d ic=%0d rm=%0d expected cyc=%0d acc=%0d vl=%0d ic=%0d rm=%0d",
                   e.tag, cyc, vrd_accept, vrd_vl, vrd_ic, vrd_rm, e.cyc, e.acc, e.vl, e.ic, e.rm);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_en[i] = 1'b0; m_tab[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (vrd_valid !== 1'b0) begin
      bad++; $display("FAIL R1: reset vrd_valid actual=%0b expected=0", vrd_valid);
    end

    // R1 deny by default
    send("R1", PREFIX, 16'd5, 32'h0A000001, 32'h0A000002, 16'd100, 16'd200, 50, 0);
    // R4/R11/R2 enable link 5 with options, no compares
    cfg_write(5, mk_entry(1, 1, 0, 4'b0000, '0, '0, '0, '0));
    send("R4_R11", PREFIX, 16'd5, 32'h0A000001, 32'h0A000002, 16'd100, 16'd200, 50, 0);
    // R3 bad prefix (byte 3 and byte 0)
    send("R3", PREFIX ^ 32'h1, 16'd5, 32'h0A000001, 32'h0A000002, 16'd100, 16'd200, 50, 0);
    send("R3", PREFIX ^ 32'h8000_0000, 16'd5, 32'h0A000001, 32'h0A000002, 16'd100, 16'd200, 50, 0);
    // R2 out of range, aliasing onto link 5
    send("R2", PREFIX, 16'd261, 32'h0A000001, 32'h0A000002, 16'd100, 16'd200, 50, 0);
    cfg_write(255, mk_entry(1, 0, 1, 4'b0000, '0, '0, '0, '0));
    send("R2_R11", PREFIX, 16'd255, 32'h0, 32'h0, 16'd0, 16'd0, 46, 0);
    // R5..R8 compares on link 9
    cfg_write(9, mk_entry(1, 1, 1, 4'b1000, 32'hC0A80101, '0, '0, '0));
    send("R5", PREFIX, 16'd9, 32'hC0A80101, 32'h11, 16'd1, 16'd2, 48, 0);
    send("R5", PREFIX, 16'd9, 32'hC0A80102, 32'h11, 16'd1, 16'd2, 48, 0);
    cfg_write(9, mk_entry(1, 1, 1, 4'b0100, 32'hC0A80101, 32'hE0000001, '0, '0));
    send("R5_R6", PREFIX, 16'd9, 32'hDEADBEEF, 32'hE0000001, 16'd1, 16'd2, 48, 0);
    send("R6", PREFIX, 16'd9, 32'hC0A80101, 32'hE0000002, 16'd1, 16'd2, 48, 0);
    cfg_write(9, mk_entry(1, 0, 1, 4'b0010, '0, 32'hE0000001, 16'hABCD, 16'h1234));
    send("R7", PREFIX, 16'd9, 32'h1, 32'h2, 16'hABCD, 16'h9999, 48, 0);
    send("R7", PREFIX, 16'd9, 32'h1, 32'h2, 16'hABCC, 16'h1234, 48, 0);
    cfg_write(9, mk_entry(1, 0, 1, 4'b0001, '0, '0, 16'hABCD, 16'h1234));
    send("R8", PREFIX, 16'd9, 32'h1, 32'h2, 16'h0, 16'h1234, 48, 0);
    send("R8", PREFIX, 16'd9, 32'h1, 32'h2, 16'hABCD, 16'h1235, 48, 0);
    // R10 runts, R9 boundary and gaps
    send("R10", PREFIX, 16'd5, 32'h1, 32'h2, 16'h3, 16'h4, 10, 0);
    send("R10", PREFIX, 16'd5, 32'h1, 32'h2, 16'h3, 16'h4, 41, 0);
    send("R10", PREFIX, 16'd5, 32'h1, 32'h2, 16'h3, 16'h4, 1, 0);
    send("R9", PREFIX, 16'd5, 32'h1, 32'h2, 16'h3, 16'h4, 42, 0);
    send("R9", PREFIX, 16'd5, 32'h1, 32'h2, 16'h3, 16'h4, 80, 1);
    send("R10", PREFIX, 16'd5, 32'h1, 32'h2, 16'h3, 16'h4, 20, 1);
    // R4 disable again
    cfg_write(5, mk_entry(0, 1, 1, 4'b0000, '0, '0, '0, '0));
    send("R4", PREFIX, 16'd5, 32'h1, 32'h2, 16'h3, 16'h4, 50, 0);

    repeat (5) @(negedge clk);
    total++;
    if (q.size() != 0) begin
      bad++; $display("FAIL R9: missing verdicts actual=%0d expected=0", q.size());
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R9: watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule